// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a wide set of peripheral interrupt requests and a small group of non-maskable trap requests into one interrupt line toward a processor core. Each peripheral source has its own enable bit, pending flag and three-bit priority, all written through a single configuration port. Every cycle the controller picks one winner and registers it. It then presents the winner's vector number and the program-memory address of that vector's slot in the handler table.

Traps always outrank peripheral sources. They ignore enables and the processor's current priority. A peripheral source is forwarded only if its priority is strictly above the processor's current level. A control bit redirects every vector lookup to a second table that follows directly after the first. The processor accepts the request with a one-cycle acknowledge. The controller then clears the winner's pending flag and raises the current level to the winner's level. The core can lower that level again through a write port when a handler returns.

Top module: `pvic_top`

## Requirements
- R1: After reset, `irq` is 0 and `vec_num`, `vec_addr`, `cpu_lvl` all read 0. While `irq` is 0, `vec_num` and `vec_addr` read 0.
- R2: A peripheral source is forwarded only when it is pending, enabled, and its priority is strictly greater than `cpu_lvl`. Priority 0 therefore never forwards.
- R3: Among forwarded peripheral sources the highest priority wins. On equal priority the lower source index wins.
- R4: Any pending trap wins over every peripheral source, regardless of enables and `cpu_lvl`. Among traps the lower trap index wins.
- R5: Trap t reports `vec_num` = t. Peripheral source s reports `vec_num` = 8 + s, giving 126 vectors with the defaults.
- R6: `vec_addr` = 0x000004 + 2·`vec_num` while `alt_sel` is 0. While it is 1, `vec_addr` = 0x000004 + 252 + 2·`vec_num`.
- R7: A request present at clock edge k becomes pending at edge k. It appears on `irq`/`vec_num` after edge k+1.
- R8: An acknowledge while `irq` is 1 clears the winner's pending flag. It sets `cpu_lvl` to the winner's level: the priority 1..7 for a peripheral source, 8 + t for trap t. It drives `irq` low in the next cycle.
- R9: A source that is masked, by a disable or by `cpu_lvl`, stays pending. It is forwarded once the mask is lifted.
- R10: `lvl_we` loads `lvl_wdata` into `cpu_lvl` when no acknowledge is accepted in the same cycle.
- R11: An acknowledge while `irq` is 0 has no effect on `cpu_lvl` or any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | N_SRC | Peripheral request per source; high in a cycle sets that source pending |
| trap_req | input | N_TRAP | Trap request per trap; high in a cycle sets that trap pending |
| cfg_we | input | 1 | Write enable for one source's enable and priority |
| cfg_idx | input | SRC_IDX_W | Source index for the configuration write |
| cfg_en | input | 1 | Enable value written |
| cfg_prio | input | 3 | Priority value written (0 = off, 1..7) |
| alt_we | input | 1 | Write enable for the table-select bit |
| alt_sel | input | 1 | Table-select value: 0 primary, 1 alternate |
| lvl_we | input | 1 | Write enable for the current processor level |
| lvl_wdata | input | 4 | Level value written |
| ack | input | 1 | Processor acknowledge of the presented request |
| irq | output | 1 | Interrupt request to the processor |
| vec_num | output | 7 | Winning vector number |
| vec_addr | output | 24 | Address of the winning vector's table slot |
| cpu_lvl | output | 4 | Current processor priority level |

## Verification
On every cycle the assertions check four things: a forwarded peripheral winner's level is above the level it was judged against, a pending trap always produces a trap vector, an accepted acknowledge lowers `irq` and loads the winner's level, and idle outputs stay zero. The bench scenarios show the parts that depend on specific inputs. These are the tie order among equal priorities, the exact vector numbers and slot addresses in both tables, the two-edge request latency, and masked sources that wait and later fire. They also cover the sequence of trap-over-trap and trap-over-peripheral service.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int PRIO_W = 3;
  localparam int LVL_W  = 4;
  localparam int VEC_W  = 7;
  localparam int ADDR_W = 24;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [LVL_W-1:0]  lvl_t;
  typedef logic [VEC_W-1:0]  vec_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic valid;
    vec_t vec;
    lvl_t lvl;
  } win_t;
endpackage

// File: rtl/pvic_src_bank.sv
module pvic_src_bank
  import pvic_pkg::*;
#(
  parameter int N_SRC = 118,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic             cfg_en_i,
  input  prio_t            cfg_prio_i,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  lvl_t             cpu_lvl_i,
  output logic [N_SRC-1:0] elig_o,
  output prio_t            prio_o [N_SRC]
);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic  pend_q, pend_d;
    logic  en_q;
    prio_t prio_q;
    logic  sel_cfg, sel_clr;

    always_comb begin
      sel_cfg = cfg_we_i && (cfg_idx_i == IDX_W'(i));
      sel_clr = clr_i && (clr_idx_i == IDX_W'(i));
      pend_d  = (pend_q && !sel_clr) || req_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q <= 1'b0;
        en_q   <= 1'b0;
        prio_q <= '0;
      end else begin
        pend_q <= pend_d;
        if (sel_cfg) begin
          en_q   <= cfg_en_i;
          prio_q <= cfg_prio_i;
        end
      end
    end

    assign elig_o[i] = pend_q && en_q && ({1'b0, prio_q} > cpu_lvl_i);
    assign prio_o[i] = prio_q;

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_clr && !req_i[i]) |=> !pend_q); // R8
  end

endmodule

// File: rtl/pvic_trap_bank.sv
module pvic_trap_bank #(
  parameter int N_TRAP = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRAP-1:0] req_i,
  input  logic              clr_i,
  input  logic [IDX_W-1:0]  clr_idx_i,
  output logic [N_TRAP-1:0] pend_o
);

  logic [N_TRAP-1:0] pend_q, pend_d;

  for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
    always_comb begin
      pend_d[t] = (pend_q[t] && !(clr_i && (clr_idx_i == IDX_W'(t)))) || req_i[t];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int N_TRAP = 8,
  parameter int N_SRC  = 118
) (
  input  logic [N_TRAP-1:0] trap_pend_i,
  input  logic [N_SRC-1:0]  elig_i,
  input  prio_t             prio_i [N_SRC],
  output win_t              win_o
);

  localparam int TRAP_LVL0 = 2 ** PRIO_W;

  always_comb begin
    win_o = '0;
    // peripheral sources: strict compare keeps the lower index on ties
    for (int i = 0; i < N_SRC; i++) begin
      if (elig_i[i] && (!win_o.valid || ({1'b0, prio_i[i]} > win_o.lvl))) begin
        win_o.valid = 1'b1;
        win_o.vec   = VEC_W'(N_TRAP + i);
        win_o.lvl   = {1'b0, prio_i[i]};
      end
    end
    // traps override; scanning downward leaves the lowest index
    for (int t = N_TRAP - 1; t >= 0; t--) begin
      if (trap_pend_i[t]) begin
        win_o.valid = 1'b1;
        win_o.vec   = VEC_W'(t);
        win_o.lvl   = LVL_W'(TRAP_LVL0 + t);
      end
    end
  end

endmodule

// File: rtl/pvic_vecgen.sv
module pvic_vecgen
  import pvic_pkg::*;
#(
  parameter int    N_VEC    = 126,
  parameter addr_t TBL_BASE = 24'h000004
) (
  input  win_t  win_i,
  input  logic  alt_i,
  output addr_t addr_o
);

  localparam addr_t ALT_OFS = addr_t'(2 * N_VEC);

  always_comb begin
    if (win_i.valid)
      addr_o = TBL_BASE + (alt_i ? ALT_OFS : '0) + {addr_t'(win_i.vec), 1'b0} >> 0;
    else
      addr_o = '0;
  end

endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int    N_TRAP    = 8,
  parameter int    N_SRC     = 118,
  parameter addr_t TBL_BASE  = 24'h000004,
  parameter int    SRC_IDX_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_SRC-1:0]     src_req,
  input  logic [N_TRAP-1:0]    trap_req,
  input  logic                 cfg_we,
  input  logic [SRC_IDX_W-1:0] cfg_idx,
  input  logic                 cfg_en,
  input  logic [2:0]           cfg_prio,
  input  logic                 alt_we,
  input  logic                 alt_sel,
  input  logic                 lvl_we,
  input  logic [3:0]           lvl_wdata,
  input  logic                 ack,
  output logic                 irq,
  output logic [6:0]           vec_num,
  output logic [23:0]          vec_addr,
  output logic [3:0]           cpu_lvl
);

  localparam int N_VEC      = N_TRAP + N_SRC;
  localparam int TRAP_IDX_W = (N_TRAP > 1) ? $clog2(N_TRAP) : 1;

  win_t              win_c, win_d, win_q;
  addr_t             addr_c, addr_d, addr_q;
  lvl_t              lvl_d, lvl_q;
  logic              alt_q;
  logic              ack_fire, clr_src, clr_trap;
  logic [N_SRC-1:0]  elig;
  prio_t             prio [N_SRC];
  logic [N_TRAP-1:0] trap_pend;

  assign ack_fire = ack && win_q.valid;
  assign clr_trap = ack_fire && (win_q.vec <  VEC_W'(N_TRAP));
  assign clr_src  = ack_fire && (win_q.vec >= VEC_W'(N_TRAP));

  pvic_src_bank #(.N_SRC(N_SRC), .IDX_W(SRC_IDX_W)) u_src (
    .clk(clk), .rst_n(rst_n), .req_i(src_req),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_en_i(cfg_en), .cfg_prio_i(cfg_prio),
    .clr_i(clr_src), .clr_idx_i(SRC_IDX_W'(win_q.vec - VEC_W'(N_TRAP))),
    .cpu_lvl_i(lvl_q), .elig_o(elig), .prio_o(prio)
  );

  pvic_trap_bank #(.N_TRAP(N_TRAP), .IDX_W(TRAP_IDX_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .req_i(trap_req),
    .clr_i(clr_trap), .clr_idx_i(TRAP_IDX_W'(win_q.vec)), .pend_o(trap_pend)
  );

  pvic_arbiter #(.N_TRAP(N_TRAP), .N_SRC(N_SRC)) u_arb (
    .trap_pend_i(trap_pend), .elig_i(elig), .prio_i(prio), .win_o(win_c)
  );

  pvic_vecgen #(.N_VEC(N_VEC), .TBL_BASE(TBL_BASE)) u_vec (
    .win_i(win_c), .alt_i(alt_q), .addr_o(addr_c)
  );

  // next state
  always_comb begin
    win_d  = ack_fire ? '0 : win_c;
    addr_d = ack_fire ? '0 : addr_c;
    if (ack_fire)    lvl_d = win_q.lvl;
    else if (lvl_we) lvl_d = lvl_wdata;
    else             lvl_d = lvl_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      addr_q <= '0;
      lvl_q  <= '0;
      alt_q  <= 1'b0;
    end else begin
      win_q  <= win_d;
      addr_q <= addr_d;
      lvl_q  <= lvl_d;
      if (alt_we) alt_q <= alt_sel;
    end
  end

  assign irq      = win_q.valid;
  assign vec_num  = win_q.vec;
  assign vec_addr = addr_q;
  assign cpu_lvl  = lvl_q;

  AST_USER_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && vec_num >= 7'(N_TRAP)) |-> (win_q.lvl > $past(lvl_q))); // R2
  AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trap_pend) && !ack_fire) |=> (irq && vec_num < 7'(N_TRAP))); // R4
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq); // R8
  AST_ACK_LOADS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> (cpu_lvl == $past(win_q.lvl))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (vec_num == '0 && vec_addr == '0)); // R1

endmodule

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  localparam int NT = 8;
  localparam int NS = 118;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NS-1:0] src_req;
  logic [NT-1:0] trap_req;
  logic          cfg_we, cfg_en, alt_we, alt_sel, lvl_we, ack;
  logic [6:0]    cfg_idx;
  logic [2:0]    cfg_prio;
  logic [3:0]    lvl_wdata;
  logic          irq;
  logic [6:0]    vec_num;
  logic [23:0]   vec_addr;
  logic [3:0]    cpu_lvl;

  always #2.5 clk = ~clk;

  pvic_top dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .trap_req(trap_req),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_prio(cfg_prio),
    .alt_we(alt_we), .alt_sel(alt_sel), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata),
    .ack(ack), .irq(irq), .vec_num(vec_num), .vec_addr(vec_addr), .cpu_lvl(cpu_lvl)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [7:0] a; logic [7:0] pa; logic [7:0] b; logic [7:0] pb;
    logic [7:0] lvl; logic [7:0] alt; logic [7:0] e_irq; logic [7:0] e_vec; logic [7:0] e_lvl;
  } ent_t;

  localparam ent_t TBL [6] = '{
    '{8'd3,  8'd2, 8'd5,   8'd6, 8'd0, 8'd0, 8'd1, 8'd13,  8'd6},  // R3 higher prio
    '{8'd10, 8'd4, 8'd2,   8'd4, 8'd0, 8'd0, 8'd1, 8'd10,  8'd4},  // R3 tie, lower index
    '{8'd7,  8'd3, 8'd9,   8'd0, 8'd0, 8'd0, 8'd1, 8'd15,  8'd3},  // R2 prio 0 off
    '{8'd7,  8'd3, 8'd9,   8'd5, 8'd5, 8'd0, 8'd0, 8'd0,   8'd0},  // R2 not above cpu
    '{8'd0,  8'd1, 8'd117, 8'd7, 8'd0, 8'd1, 8'd1, 8'd125, 8'd7},  // R6 alt, last source
    '{8'd20, 8'd7, 8'd21,  8'd7, 8'd3, 8'd1, 8'd1, 8'd28,  8'd7}   // R3 tie at top, alt
  };

  function automatic int exp_addr(int v, bit alt);
    return 4 + (alt ? 252 : 0) + 2 * v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    src_req = '0; trap_req = '0; cfg_we = 0; cfg_en = 0; cfg_idx = '0; cfg_prio = '0;
    alt_we = 0; alt_sel = 0; lvl_we = 0; lvl_wdata = '0; ack = 0;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic cfg(int idx, bit en, int p);
    cfg_we = 1; cfg_idx = 7'(idx); cfg_en = en; cfg_prio = 3'(p);
    tick();
    cfg_we = 0;
  endtask

  task automatic set_lvl(int l);
    lvl_we = 1; lvl_wdata = 4'(l);
    tick();
    lvl_we = 0;
  endtask

  task automatic set_alt(bit a);
    alt_we = 1; alt_sel = a;
    tick();
    alt_we = 0;
  endtask

  task automatic do_ack();
    ack = 1;
    tick();
    ack = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check("R1 irq", irq, 0);
    check("R1 vec_num", vec_num, 0);
    check("R1 vec_addr", vec_addr, 0);
    check("R1 cpu_lvl", cpu_lvl, 0);

    // table walk
    for (int k = 0; k < 6; k++) begin
      do_reset();
      cfg(TBL[k].a, 1'b1, TBL[k].pa);
      cfg(TBL[k].b, 1'b1, TBL[k].pb);
      set_lvl(TBL[k].lvl);
      set_alt(TBL[k].alt[0]);
      src_req[TBL[k].a] = 1'b1;
      src_req[TBL[k].b] = 1'b1;
      tick();
      src_req = '0;
      tick();
      check("R2/R3 irq", irq, TBL[k].e_irq);
      check("R3/R5 vec_num", vec_num, TBL[k].e_irq ? TBL[k].e_vec : 0);
      check("R6 vec_addr", vec_addr, TBL[k].e_irq ? exp_addr(TBL[k].e_vec, TBL[k].alt[0]) : 0);
      if (TBL[k].e_irq != 0) begin
        do_ack();
        check("R8 irq after ack", irq, 0);
        check("R8 cpu_lvl after ack", cpu_lvl, TBL[k].e_lvl);
      end
    end

    // R7 latency, then R8 pending cleared
    do_reset();
    cfg(4, 1'b1, 5);
    src_req[4] = 1'b1;
    tick();
    src_req = '0;
    check("R7 irq after first edge", irq, 0);
    tick();
    check("R7 irq after second edge", irq, 1);
    check("R5 vec_num src4", vec_num, 12);
    do_ack();
    check("R8 cpu_lvl", cpu_lvl, 5);
    set_lvl(0);
    tick();
    check("R8 pending cleared", irq, 0);

    // R4 traps, R5 trap vectors, R10 level write, R9 masked source waits
    do_reset();
    cfg(1, 1'b1, 7);
    set_lvl(15);
    trap_req[2] = 1'b1; trap_req[5] = 1'b1; src_req[1] = 1'b1;
    tick();
    trap_req = '0; src_req = '0;
    tick();
    check("R4 trap2 wins", vec_num, 2);
    check("R4 irq despite cpu 15", irq, 1);
    check("R6 trap2 addr", vec_addr, 8);
    do_ack();
    check("R8 trap lvl", cpu_lvl, 10);
    tick();
    check("R4 trap5 next", vec_num, 5);
    check("R6 trap5 addr", vec_addr, 14);
    do_ack();
    check("R8 trap5 lvl", cpu_lvl, 13);
    tick();
    check("R2 masked by cpu", irq, 0);
    set_lvl(0);
    check("R10 level write", cpu_lvl, 0);
    tick();
    check("R9 released", irq, 1);
    check("R9 released vec", vec_num, 9);

    // R9 disabled source held pending
    do_reset();
    cfg(6, 1'b0, 5);
    src_req[6] = 1'b1;
    tick();
    src_req = '0;
    tick();
    check("R9 disabled not forwarded", irq, 0);
    cfg(6, 1'b1, 5);
    tick();
    check("R9 enabled later", irq, 1);
    check("R9 vec", vec_num, 14);

    // R11 ack while idle
    do_reset();
    set_lvl(3);
    do_ack();
    check("R11 cpu_lvl", cpu_lvl, 3);
    check("R11 irq", irq, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule